// File: doc/BRIEF.md
# Cascaded Two-Three Cell Programmable Frequency Divider

This block divides an already prescaled clock by any whole ratio from 32 to 63. Its output is the feedback pulse that goes to the phase detector of a fractional or integer synthesizer loop. The ratio is set by a 5-bit programming word P, and the divide ratio is N = 32 + P. Each bit of P weights the output period by its own power of two.

The divider is a chain of identical divide-by-two-or-three cells. Each cell hands a tick forward to the next cell once per its own output period. It also hands a modulus request backward to the cell before it. A cell whose program bit is set stretches one of its periods by one input tick when its request input is active. The request input of the last cell is held active, so every cell stretches at most once per full output period.

The cells run synchronously on the input clock and use clock enables, not rippled clocks. The programming word is captured at reset and again at every output-period boundary. A word changed in mid-period therefore never shortens or stretches the period that is in progress.

Top module: `divChainTop`

## Requirements
- R1: With programming word P held steady, consecutive rising edges of `divOut` are exactly 32 + P input clock cycles apart.
- R2: With P = 0 (all bits clear), the spacing between output rising edges is 32 cycles, and no spacing is ever shorter than 32.
- R3: With P = 31 (all bits set), the spacing between output rising edges is 63 cycles, and no spacing is ever longer than 63.
- R4: A change of `progIn` made partway through an output period leaves that period's length unchanged. The new word governs the period that begins at the next rising edge of `divOut`.
- R5: While `rst` is sampled high at a clock edge, `divOut` is low after that edge. After release, the first rising edge of `divOut` follows the Nth rising clock edge after the last edge at which `rst` was high.
- R6: `divOut` is high for exactly one input clock cycle per output period.
- R7: The word present on `progIn` during reset sets the length of the first output period after release.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset; clears every cell and captures `progIn` |
| progIn | input | 5 | Programming word P; the ratio is 32 + P |
| divOut | output | 1 | Divided output; one-cycle-high pulse every N input cycles |

## Verification
The bench builds the block with its default chain length of five cells. At that length, every one of the 32 programming words can be swept and each resulting period can be measured edge to edge. This covers both extreme ratios as well as every single-bit and mixed weighting. A behavioural cycle counter in the bench predicts `divOut` on every clock. It also predicts the effect of words changed mid-period and of resets issued mid-period. This makes the period-boundary capture of the word and the exact position of the first edge after reset visible cycle by cycle.

// File: rtl/divChainPkg.sv
package divChainPkg;

  // Strobes issued by the control to the cell datapath.
  typedef struct packed {
    logic clearCells;  // force every cell to its first phase
    logic loadWord;    // capture the programming word
  } dpStrobe_t;

  localparam int unsigned PhaseW = 2;

endpackage

// File: rtl/divCell.sv
module divCell
  import divChainPkg::*;
(
  input  logic clk,
  input  logic clearCell,
  input  logic tickIn,    // one input period of this cell elapsed
  input  logic modIn,     // stretch request from the following cell
  input  logic progBit,   // this cell's weight bit
  output logic tickOut,   // one output period of this cell elapsed
  output logic modOut     // stretch request toward the preceding cell
);

  logic [PhaseW-1:0] phase;
  logic [PhaseW-1:0] lastPhase;
  logic              finalPhase;

  // Three input periods when both the bit and the request are set, else two.
  assign lastPhase  = (progBit && modIn) ? PhaseW'(2) : PhaseW'(1);
  assign finalPhase = (phase >= lastPhase);

  assign tickOut = tickIn && finalPhase;
  // The preceding cell may stretch only in this cell's final input period.
  assign modOut  = modIn && finalPhase;

  always_ff @(posedge clk) begin
    if (clearCell) begin
      phase <= '0;
    end else if (tickIn) begin
      phase <= finalPhase ? '0 : phase + PhaseW'(1);
    end
  end

endmodule

// File: rtl/divChainDatapath.sv
module divChainDatapath
  import divChainPkg::*;
#(
  parameter int unsigned NumCells = 5
) (
  input  logic                clk,
  input  dpStrobe_t           strobes,
  input  logic [NumCells-1:0] progIn,
  output logic                periodEnd
);

  logic [NumCells-1:0] activeWord;
  logic [NumCells:0]   tickBus;
  logic [NumCells:0]   modBus;

  always_ff @(posedge clk) begin
    if (strobes.loadWord) begin
      activeWord <= progIn;
    end
  end

  assign tickBus[0]        = 1'b1;      // the first cell sees every input cycle
  assign modBus[NumCells]  = 1'b1;      // the last cell always may stretch

  for (genvar gi = 0; gi < NumCells; gi++) begin : g_cell
    divCell cell_i (
      .clk       (clk),
      .clearCell (strobes.clearCells),
      .tickIn    (tickBus[gi]),
      .modIn     (modBus[gi+1]),
      .progBit   (activeWord[gi]),
      .tickOut   (tickBus[gi+1]),
      .modOut    (modBus[gi])
    );
  end

  // The last tick and the head request both mark the final input cycle.
  assign periodEnd = tickBus[NumCells] && modBus[0];

endmodule

// File: rtl/divChainControl.sv
module divChainControl
  import divChainPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      periodEnd,
  output dpStrobe_t strobes,
  output logic      divOut
);

  always_comb begin
    strobes.clearCells = rst;
    strobes.loadWord   = rst || periodEnd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divOut <= 1'b0;
    end else begin
      divOut <= periodEnd;
    end
  end

endmodule

// File: rtl/divChainTop.sv
module divChainTop
  import divChainPkg::*;
#(
  parameter int unsigned NumCells = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NumCells-1:0] progIn,
  output logic                divOut
);

  dpStrobe_t strobes;
  logic      periodEnd;

  divChainControl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .periodEnd (periodEnd),
    .strobes   (strobes),
    .divOut    (divOut)
  );

  divChainDatapath #(.NumCells(NumCells)) dp_i (
    .clk       (clk),
    .strobes   (strobes),
    .progIn    (progIn),
    .periodEnd (periodEnd)
  );

endmodule

// File: rtl/divChainChecker.sv
module divChainChecker #(
  parameter int unsigned NumCells = 5
) (
  input logic clk,
  input logic rst,
  input logic divOut
);

  localparam int unsigned MinRatio = 1 << NumCells;
  localparam int unsigned MaxRatio = 2 * MinRatio - 1;
  localparam int unsigned GapW     = NumCells + 2;
  localparam logic [GapW-1:0] GapSat = {GapW{1'b1}};

  // Cycles since the last output pulse or since reset.
  logic [GapW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0;
    end else if (divOut) begin
      gap <= GapW'(1);
    end else if (gap != GapSat) begin
      gap <= gap + GapW'(1);
    end
  end

  // R2: spacing never below the minimum ratio
  p_gap_floor_r2: assert property (@(posedge clk) disable iff (rst)
    divOut |-> (gap >= GapW'(MinRatio)));

  // R3: spacing never above the maximum ratio
  p_gap_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
    divOut |-> (gap <= GapW'(MaxRatio)));

  // R3: output may not stay quiet past the maximum ratio
  p_no_stall_r3: assert property (@(posedge clk) disable iff (rst)
    !divOut |-> (gap < GapW'(MaxRatio)));

  // R6: one-cycle pulse
  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    divOut |=> !divOut);

  // R5: reset silences the output
  p_reset_quiet_r5: assert property (@(posedge clk)
    rst |=> !divOut);

endmodule

bind divChainTop divChainChecker #(.NumCells(NumCells)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .divOut (divOut)
);

// File: tb/divChainTop_tb_top.sv
module divChainTop_tb_top;

  localparam int NumCells = 5;
  localparam int BaseN    = 32;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NumCells-1:0] progIn = '0;
  logic                divOut;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  string phaseTag = "R5";

  // reference model state
  int  mCnt  = 0;
  int  mWord = 0;
  logic expOut = 1'b0;

  always #5 clk = ~clk;

  divChainTop #(.NumCells(NumCells)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .progIn (progIn),
    .divOut (divOut)
  );

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // behavioural counter model, updated at each edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mCnt = 0; mWord = int'(progIn); expOut = 1'b0;
    end else if (mCnt + 1 == BaseN + mWord) begin
      expOut = 1'b1; mCnt = 0; mWord = int'(progIn);
    end else begin
      expOut = 1'b0; mCnt++;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      finishRun();
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    vectors++;
    if (divOut !== expOut) begin
      fails++;
      $display("FAIL %s: divOut actual %b expected %b at cycle %0d", phaseTag, divOut, expOut, cycles);
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    vectors++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // wait for next rising edge of divOut; return cycles waited
  task automatic waitRise(output int waited);
    logic prev;
    waited = 0;
    prev = divOut;
    forever begin
      @(negedge clk);
      waited++;
      if (divOut && !prev) break;
      prev = divOut;
    end
  endtask

  task automatic measure(input int word, input string tag);
    int w;
    @(negedge clk);
    progIn = NumCells'(word);
    waitRise(w);          // word captured here
    waitRise(w);          // full period under the new word
    check(tag, w, BaseN + word);
  endtask

  initial begin
    int w;
    // R5: reset state and first edge position
    phaseTag = "R5";
    progIn = NumCells'(9);
    repeat (3) @(negedge clk);
    check("R5 reset output", int'(divOut), 0);
    rst = 1'b0;
    waitRise(w);
    check("R5/R7 first edge after release", w, BaseN + 9);

    // R1/R2/R3: sweep every word
    phaseTag = "R1";
    for (int p = 0; p < 32; p++) begin
      if (p == 0)       measure(p, "R2 all-zero word");
      else if (p == 31) measure(p, "R3 all-ones word");
      else              measure(p, "R1 period");
    end

    // R6: pulse width
    phaseTag = "R6";
    waitRise(w);
    @(negedge clk);
    check("R6 pulse width", int'(divOut), 0);

    // R4: mid-period word change
    phaseTag = "R4";
    @(negedge clk);
    progIn = NumCells'(5);
    waitRise(w);
    waitRise(w);
    repeat (10) @(negedge clk);
    progIn = NumCells'(20);
    waitRise(w);
    check("R4 period in progress", w + 10, BaseN + 5);
    waitRise(w);
    check("R4 next period", w, BaseN + 20);

    // R5/R7: reset in mid-period with a new word
    phaseTag = "R7";
    repeat (7) @(negedge clk);
    rst = 1'b1;
    progIn = NumCells'(31);
    repeat (2) @(negedge clk);
    check("R5 output held low in reset", int'(divOut), 0);
    rst = 1'b0;
    progIn = NumCells'(0);
    waitRise(w);
    check("R7 first period uses reset word", w, BaseN + 31);
    waitRise(w);
    check("R1 following period", w, BaseN);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule